// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block sits beside a 16-bit free-running timer and turns compare matches into edges on up to eight timer pins. Each channel holds a 16-bit compare value. In any clock cycle where the timer is enabled and its count equals that value, the channel's 2-bit action code chooses what happens to the channel's output line: nothing, a toggle, a forced low or a forced high. The new line state is latched on the following clock edge. It persists until the next match.

Software reaches the block through a byte-wide register bus. The bus has a write strobe and a read strobe, and read data is returned one cycle after the read strobe. Two control bytes hold the eight action codes. Three further bytes choose how each pin is used:

- an override mask byte,
- an output-disable byte,
- a general-purpose data byte.

A pin is handed to its compare channel only when three conditions all hold: its action code is non-zero, its mask bit is clear and its disable bit is clear. In every other case the pin's output-enable is low and the pin carries the general-purpose data bit instead. A sticky match flag per channel records each match and is cleared by writing 1 to it.

Top module: `oc_pin_action`

## Requirements
- R1: With action code 00, a compare match leaves that channel's output line unchanged.
- R2: With action code 01, a compare match inverts that channel's output line.
- R3: With action code 10, a match drives the line to 0, and with code 11 it drives the line to 1. The line changes on the clock edge that closes the match cycle. The pins show the change one edge later.
- R4: A match occurs only in a cycle where the timer enable input is 1 and the count input equals the channel's compare value. A differing count, or a low enable, causes no action.
- R5: A channel owns its pin when its code is non-zero, its mask bit is 0 and its disable bit is 0. An owned pin has pin_oe = 1 and pin_out equal to the channel's line state.
- R6: When a channel's bit in the override mask register (address 0x00) is 1, the channel does not own its pin. Its line state still follows matches.
- R7: When a channel's bit in the output-disable register (address 0x01) is 1, the channel does not own its pin.
- R8: When a pin is not owned, pin_oe is 0 and pin_out equals the matching bit of the general-purpose data register (address 0x02).
- R9: Control byte 0x08 holds the codes for channels 7 to 4, and control byte 0x09 holds the codes for channels 3 to 0. Channel k occupies bits 2(k mod 4)+1 (the high code bit) and 2(k mod 4) (the low code bit). Both bytes reset to 0 and can be read and written at any time.
- R10: Writes to unimplemented addresses (0x04 to 0x07 and 0x0A to 0x0F) change nothing, and reads from those addresses return 0.
- R11: The match flag register (address 0x03, bit k for channel k) sets a bit on each match of that channel. Writing 1 to a bit clears it. If a match and a clear land in the same cycle, the bit stays set.
- R12: Every line state resets to 0 and holds its value in cycles without a match.
- R13: The compare value of channel k is written and read as a high byte at address 0x10+2k and a low byte at address 0x11+2k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| tcnt | input | 16 | Timer count value |
| tmr_en | input | 1 | Timer enable |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
Two events can collide in one cycle. The first collision is a compare match and a bus write that clears that channel's match flag. The bench provokes it by presenting the matching count and the write-1-to-clear strobe together. It then reads the flag back and expects the set to win. The second collision is a match landing on a pin that is masked or disabled. The bench checks that the line state still moves underneath, which shows up as the toggled level once the pin is released.

// File: rtl/oca_pkg.sv
package oca_pkg;
  localparam int NCH    = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  localparam logic [ADDR_W-1:0] A_MASK = 5'h00;
  localparam logic [ADDR_W-1:0] A_DIS  = 5'h01;
  localparam logic [ADDR_W-1:0] A_GPD  = 5'h02;
  localparam logic [ADDR_W-1:0] A_FLAG = 5'h03;
  localparam logic [ADDR_W-1:0] A_CTLH = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTLL = 5'h09;
endpackage

// File: rtl/oca_regs.sv
module oca_regs
  import oca_pkg::*;
#(
  parameter int N = NCH,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      match,
  output logic [DATA_W-1:0] rdata,
  output logic [2*N-1:0]    codes,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      dis,
  output logic [N-1:0]      gpd,
  output logic [N*CW-1:0]   cmp_flat
);
  localparam int CH_W = $clog2(N);

  logic [DATA_W-1:0] ctl_hi_q, ctl_lo_q;
  logic [N-1:0]      mask_q, dis_q, gpd_q, flag_q;
  logic [CW-1:0]     cmp_q [N];
  logic [N-1:0]      flag_clr;
  logic [DATA_W-1:0] rd_nxt;
  logic [CH_W-1:0]   sel;

  assign sel      = addr[CH_W:1];
  assign flag_clr = (wr && addr == A_FLAG) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_hi_q <= '0;
      ctl_lo_q <= '0;
      mask_q   <= '0;
      dis_q    <= '0;
      gpd_q    <= '0;
    end else if (wr) begin
      case (addr)
        A_MASK: mask_q   <= wdata;
        A_DIS:  dis_q    <= wdata;
        A_GPD:  gpd_q    <= wdata;
        A_CTLH: ctl_hi_q <= wdata;
        A_CTLL: ctl_lo_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~flag_clr) | match;
  end

  for (genvar k = 0; k < N; k++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[k] <= '0;
      end else if (wr && addr[ADDR_W-1] && sel == CH_W'(k)) begin
        if (addr[0]) cmp_q[k][7:0]  <= wdata;
        else         cmp_q[k][15:8] <= wdata;
      end
    end
    assign cmp_flat[k*CW +: CW] = cmp_q[k];

    // R11: a match always leaves its flag set, even against a clear
    a_r11_flag_set: assert property (@(posedge clk) disable iff (rst)
      match[k] |=> flag_q[k]);
  end

  always_comb begin
    rd_nxt = '0;
    if (addr[ADDR_W-1]) begin
      rd_nxt = addr[0] ? cmp_q[sel][7:0] : cmp_q[sel][15:8];
    end else begin
      case (addr)
        A_MASK: rd_nxt = mask_q;
        A_DIS:  rd_nxt = dis_q;
        A_GPD:  rd_nxt = gpd_q;
        A_FLAG: rd_nxt = flag_q;
        A_CTLH: rd_nxt = ctl_hi_q;
        A_CTLL: rd_nxt = ctl_lo_q;
        default: rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_nxt;
  end

  assign codes = {ctl_hi_q, ctl_lo_q};
  assign mask  = mask_q;
  assign dis   = dis_q;
  assign gpd   = gpd_q;

  // R10: a write to a hole leaves the control bytes untouched
  a_r10_hole_write: assert property (@(posedge clk) disable iff (rst)
    (wr && !addr[ADDR_W-1] && addr[3] && addr[2:1] != 2'b00) |=> $stable(codes));
endmodule

// File: rtl/oca_channel.sv
module oca_channel
  import oca_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tcnt,
  input  logic          tmr_en,
  input  logic [CW-1:0] cmp,
  input  logic [1:0]    code,
  output logic          match,
  output logic          state_q
);
  act_e act;
  assign act   = act_e'(code);
  assign match = tmr_en && (tcnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
    end else if (match) begin
      case (act)
        ACT_TOGGLE: state_q <= ~state_q;
        ACT_CLEAR:  state_q <= 1'b0;
        ACT_SET:    state_q <= 1'b1;
        default:    state_q <= state_q;
      endcase
    end
  end

  a_r1_none_holds: assert property (@(posedge clk) disable iff (rst)
    (match && code == 2'b00) |=> $stable(state_q));
  a_r2_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (match && code == 2'b01) |=> (state_q != $past(state_q)));
  a_r3_clear_low: assert property (@(posedge clk) disable iff (rst)
    (match && code == 2'b10) |=> !state_q);
  a_r3_set_high: assert property (@(posedge clk) disable iff (rst)
    (match && code == 2'b11) |=> state_q);
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !match |=> $stable(state_q));
endmodule

// File: rtl/oca_pin_mux.sv
module oca_pin_mux #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] codes,
  input  logic [N-1:0]   mask,
  input  logic [N-1:0]   dis,
  input  logic [N-1:0]   gpd,
  input  logic [N-1:0]   state,
  output logic [N-1:0]   pin_out,
  output logic [N-1:0]   pin_oe
);
  for (genvar k = 0; k < N; k++) begin : g_pin
    logic owned;
    assign owned = (|codes[2*k +: 2]) && !mask[k] && !dis[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[k]  <= 1'b0;
        pin_out[k] <= 1'b0;
      end else begin
        pin_oe[k]  <= owned;
        pin_out[k] <= owned ? state[k] : gpd[k];
      end
    end

    a_r6_mask_releases: assert property (@(posedge clk) disable iff (rst)
      mask[k] |=> !pin_oe[k]);
    a_r7_dis_releases: assert property (@(posedge clk) disable iff (rst)
      dis[k] |=> !pin_oe[k]);
    a_r8_gp_value: assert property (@(posedge clk) disable iff (rst)
      (codes[2*k +: 2] == 2'b00) |=> (pin_out[k] == $past(gpd[k])));
    a_r5_owned_drives: assert property (@(posedge clk) disable iff (rst)
      (codes[2*k +: 2] != 2'b00 && !mask[k] && !dis[k]) |=> (pin_oe[k] && pin_out[k] == $past(state[k])));
  end
endmodule

// File: rtl/oc_pin_action.sv
module oc_pin_action
  import oca_pkg::*;
#(
  parameter int N  = NCH,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CW-1:0]     tcnt,
  input  logic              tmr_en,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe
);
  logic [2*N-1:0]  codes;
  logic [N-1:0]    mask, dis, gpd, match, state;
  logic [N*CW-1:0] cmp_flat;

  oca_regs #(.N(N), .CW(CW)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .match(match), .rdata(bus_rdata), .codes(codes),
    .mask(mask), .dis(dis), .gpd(gpd), .cmp_flat(cmp_flat)
  );

  for (genvar k = 0; k < N; k++) begin : g_ch
    oca_channel #(.CW(CW)) ch_i (
      .clk(clk), .rst(rst), .tcnt(tcnt), .tmr_en(tmr_en),
      .cmp(cmp_flat[k*CW +: CW]), .code(codes[2*k +: 2]),
      .match(match[k]), .state_q(state[k])
    );
  end

  oca_pin_mux #(.N(N)) mux_i (
    .clk(clk), .rst(rst), .codes(codes), .mask(mask), .dis(dis),
    .gpd(gpd), .state(state), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/oc_pin_action_tb_top.sv
module oc_pin_action_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tmr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] tcnt = 16'hFFFF;
  logic [7:0]  pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ctl = '0;
  logic [7:0]  m_mask = '0, m_dis = '0, m_gpd = '0, m_st = '0, m_flag = '0;
  logic [7:0]  rv;

  always #2 clk = ~clk;

  oc_pin_action dut_i (.*);

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [15:0] cmpv(input int k);
    return 16'h1000 + 16'(k) * 16'h0101;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_ctl(input logic [15:0] v);
    wr(5'h08, v[15:8]); wr(5'h09, v[7:0]); m_ctl = v;
  endtask

  // update the model for one match on channel k (R1, R2, R3)
  task automatic model_hit(input int k);
    case (m_ctl[2*k +: 2])
      2'b01: m_st[k] = ~m_st[k];
      2'b10: m_st[k] = 1'b0;
      2'b11: m_st[k] = 1'b1;
      default: ;
    endcase
    m_flag[k] = 1'b1;
  endtask

  task automatic pulse(input logic [15:0] v, input logic en);
    @(negedge clk); tcnt = v; tmr_en = en;
    @(negedge clk); tcnt = 16'hFFFF; tmr_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic chk_pins(input string req);
    logic [7:0] oe, o;
    for (int k = 0; k < 8; k++) begin
      oe[k] = (m_ctl[2*k +: 2] != 2'b00) && !m_mask[k] && !m_dis[k];
      o[k]  = oe[k] ? m_st[k] : m_gpd[k];
    end
    chk({req, " oe"}, {8'h0, pin_oe}, {8'h0, oe});
    chk({req, " out"}, {8'h0, pin_out}, {8'h0, o});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 R9 reset state
    chk_pins("R12 reset");
    rd(5'h08, rv); chk("R9 ctl hi reset", {8'h0, rv}, 16'h0);
    rd(5'h09, rv); chk("R9 ctl lo reset", {8'h0, rv}, 16'h0);
    rd(5'h03, rv); chk("R11 flag reset", {8'h0, rv}, 16'h0);

    // R13 compare layout
    for (int k = 0; k < 8; k++) begin
      wr(5'h10 + 5'(2*k), cmpv(k)[15:8]);
      wr(5'h11 + 5'(2*k), cmpv(k)[7:0]);
    end
    for (int k = 0; k < 8; k++) begin
      logic [7:0] h, l;
      rd(5'h10 + 5'(2*k), h); rd(5'h11 + 5'(2*k), l);
      chk("R13 compare readback", {h, l}, cmpv(k));
    end

    // R8 general-purpose data while no code is set
    wr(5'h02, 8'hA5); m_gpd = 8'hA5;
    repeat (2) @(negedge clk);
    chk_pins("R8 gp data");

    // sweep the uniform codes: set, none, toggle, toggle, clear
    for (int s = 0; s < 5; s++) begin
      logic [1:0] c;
      c = (s == 0) ? 2'b11 : (s == 1) ? 2'b00 : (s == 4) ? 2'b10 : 2'b01;
      set_ctl({8{c}});
      rd(5'h08, rv); chk("R9 ctl hi readback", {8'h0, rv}, {8'h0, m_ctl[15:8]});
      for (int k = 0; k < 8; k++) begin
        pulse(cmpv(k), 1'b1); model_hit(k);
        chk_pins(c == 2'b00 ? "R1 none" : c == 2'b01 ? "R2 toggle" : "R3 set/clear R5");
      end
    end

    // R9 mixed codes exercise per-channel field positions
    set_ctl(16'hE41B);
    for (int k = 0; k < 8; k++) begin
      pulse(cmpv(k), 1'b1); model_hit(k);
      chk_pins("R9 mixed layout");
    end
    for (int k = 0; k < 8; k++) begin
      pulse(cmpv(k), 1'b1); model_hit(k);
    end
    chk_pins("R9 mixed second pass");

    // R4 no action when disabled or off by one
    set_ctl(16'h5555);
    pulse(cmpv(0), 1'b0);
    chk_pins("R4 timer disabled");
    pulse(cmpv(1) + 16'h1, 1'b1);
    chk_pins("R4 count mismatch");

    // R6 masked pins released; state still moves underneath
    wr(5'h00, 8'h0F); m_mask = 8'h0F;
    repeat (2) @(negedge clk);
    chk_pins("R6 mask");
    pulse(cmpv(1), 1'b1); model_hit(1);
    chk_pins("R6 masked match");
    wr(5'h00, 8'h00); m_mask = 8'h00;
    repeat (2) @(negedge clk);
    chk_pins("R6 unmask shows toggled state");

    // R7 disable bits
    wr(5'h01, 8'hF0); m_dis = 8'hF0;
    repeat (2) @(negedge clk);
    chk_pins("R7 disable");
    wr(5'h01, 8'h00); m_dis = 8'h00;

    // R10 holes
    wr(5'h05, 8'hFF); wr(5'h0A, 8'h00); wr(5'h0F, 8'hFF);
    rd(5'h05, rv); chk("R10 hole read 05", {8'h0, rv}, 16'h0);
    rd(5'h0A, rv); chk("R10 hole read 0A", {8'h0, rv}, 16'h0);
    rd(5'h08, rv); chk("R10 ctl hi intact", {8'h0, rv}, 16'h0055);
    rd(5'h09, rv); chk("R10 ctl lo intact", {8'h0, rv}, 16'h0055);
    chk_pins("R10 pins intact");

    // R11 flags
    rd(5'h03, rv); chk("R11 flags accumulated", {8'h0, rv}, {8'h0, m_flag});
    wr(5'h03, 8'hFF); m_flag = '0;
    rd(5'h03, rv); chk("R11 flags cleared", {8'h0, rv}, 16'h0);
    pulse(cmpv(2), 1'b1); model_hit(2);
    rd(5'h03, rv); chk("R11 single flag", {8'h0, rv}, 16'h0004);
    // collision: clear-all write and channel 5 match in one cycle
    @(negedge clk);
    tcnt = cmpv(5); tmr_en = 1'b1;
    bus_wr = 1'b1; bus_addr = 5'h03; bus_wdata = 8'hFF;
    @(negedge clk);
    tcnt = 16'hFFFF; bus_wr = 1'b0;
    model_hit(5); m_flag = 8'h20;
    rd(5'h03, rv); chk("R11 set wins over clear", {8'h0, rv}, 16'h0020);

    // R12 hold across idle cycles
    repeat (20) @(negedge clk);
    chk_pins("R12 idle hold");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule